// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

A 32-bit processor core that completes one instruction in every clock cycle. In each cycle it fetches a word from an instruction port and splits it into fixed fields. It reads two source registers from a 32 by 32-bit register file. It forms the second operand from either a register or an extended 16-bit immediate, runs an add, subtract or OR, and then either writes back, stores to data memory or steers the program counter. The supported operations are register add and subtract, OR with a zero-extended immediate, word load, word store, and branch on equality.

Both memories live outside the core. Instruction fetch is a combinational read addressed by the program counter. Data memory has a combinational read and is written on the clock edge while the write strobe is high. The program counter, the register file and the external data memory all update on the same rising edge. A value written by one instruction is therefore visible to the next one without any forwarding.

Top module: `onecyc_cpu`

## Requirements
- R1: While synchronous active-high reset is high, the program counter is loaded with 0 at each rising edge, and no register or data memory write is issued.
- R2: Every instruction that is not a branch advances the program counter by 4 (`imem_addr` steps by 4).
- R3: Opcode 0x00 with function code 0x21 (bits 5:0) writes rs + rt (modulo 2^32) into the register named by bits 15:11.
- R4: Opcode 0x00 with function code 0x23 writes rs - rt (modulo 2^32) into the register named by bits 15:11.
- R5: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate (bits 15:0) into the register named by bits 20:16.
- R6: Opcode 0x23 drives `dmem_addr` = rs + sign-extended immediate and writes `dmem_rdata` into the register named by bits 20:16.
- R7: Opcode 0x2B drives `dmem_addr` = rs + sign-extended immediate and `dmem_wdata` = rt with `dmem_we` high, and writes no register. No other instruction raises `dmem_we`.
- R8: Opcode 0x04 sets the next PC to PC + 4 + (sign-extended immediate × 4) when rs equals rt, and to PC + 4 otherwise. Both forward and backward offsets are supported.
- R9: Register 0 reads as zero, and writes to it have no effect.
- R10: Any other opcode, and opcode 0x00 with any other function code, changes no register and no memory and only advances the PC by 4.
- R11: A register written by an instruction holds the new value when the very next instruction reads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word returned combinationally for `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (second source register) |
| dmem_we | output | 1 | Data memory write strobe, sampled on the rising edge |
| dmem_rdata | input | 32 | Load data returned combinationally for `dmem_addr` |

## Verification
In one cycle a register write-back and the following instruction's read of the same register meet at a single clock edge. A branch decision that depends on a freshly written register meets the program counter update at that same edge. The test program provokes both. It has an add that updates a loop counter followed at once by an equality branch on that counter, and an add whose result is stored by the very next instruction. The bench judges the outcome against a hand-computed trace of fetch addresses and a queue of expected store address/data pairs. A stale read would show up there as a wrong loop count or wrong stored value.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_LOAD = 6'h23;
    localparam logic [5:0] OPC_STOR = 6'h2B;
    localparam logic [5:0] OPC_BREQ = 6'h04;
    localparam logic [5:0] FN_ADD   = 6'h21;
    localparam logic [5:0] FN_SUB   = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] sh;
        logic [5:0] fn;
    } instr_t;

    typedef struct packed {
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    ext_signed;
        logic    wb_from_mem;
        logic    mem_write;
        logic    reg_write;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [15:0] imm_of(instr_t i);
        return {i.rd, i.sh, i.fn};
    endfunction

    function automatic logic [XLEN-1:0] extend16(logic [15:0] v, logic sgn);
        return {{(XLEN-16){sgn & v[15]}}, v};
    endfunction

endpackage

// File: rtl/onecyc_decode.sv
module onecyc_decode
    import onecyc_pkg::*;
(
    input  instr_t ins,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        case (ins.op)
            OPC_REG: begin
                if (ins.fn == FN_ADD || ins.fn == FN_SUB) begin
                    ctl.dst_is_rd = 1'b1;
                    ctl.reg_write = 1'b1;
                    ctl.alu_op    = (ins.fn == FN_SUB) ? ALU_SUB : ALU_ADD;
                end
            end
            OPC_ORI: begin
                ctl.b_is_imm  = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.alu_op    = ALU_OR;
            end
            OPC_LOAD: begin
                ctl.b_is_imm    = 1'b1;
                ctl.ext_signed  = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.reg_write   = 1'b1;
            end
            OPC_STOR: begin
                ctl.b_is_imm   = 1'b1;
                ctl.ext_signed = 1'b1;
                ctl.mem_write  = 1'b1;
            end
            OPC_BREQ: begin
                ctl.ext_signed = 1'b1;
                ctl.is_branch  = 1'b1;
                ctl.alu_op     = ALU_SUB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/onecyc_regfile.sv
module onecyc_regfile #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [AW-1:0]    ra_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);
    logic [WIDTH-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
    import onecyc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/onecyc_cpu.sv
module onecyc_cpu
    import onecyc_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    logic [XLEN-1:0] pc_q, pc_d, pc_inc, pc_tgt;
    instr_t          ins;
    ctrl_t           ctl;
    logic [XLEN-1:0] src_a, src_b, imm_x, alu_b, alu_y, wb_val;
    logic            alu_zero;
    logic [RAW-1:0]  dst;

    assign ins = instr_t'(imem_rdata);

    onecyc_decode u_dec (
        .ins (ins),
        .ctl (ctl)
    );

    assign dst    = ctl.dst_is_rd ? RAW'(ins.rd) : RAW'(ins.rt);
    assign wb_val = ctl.wb_from_mem ? dmem_rdata : alu_y;

    onecyc_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_rf (
        .clk  (clk),
        .ra_a (RAW'(ins.rs)),
        .ra_b (RAW'(ins.rt)),
        .rd_a (src_a),
        .rd_b (src_b),
        .we   (ctl.reg_write && !rst),
        .wa   (dst),
        .wd   (wb_val)
    );

    assign imm_x = extend16(imm_of(ins), ctl.ext_signed);
    assign alu_b = ctl.b_is_imm ? imm_x : src_b;

    onecyc_alu #(.WIDTH(XLEN)) u_alu (
        .op   (ctl.alu_op),
        .a    (src_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign pc_inc = pc_q + XLEN'(4);
    assign pc_tgt = pc_inc + {imm_x[XLEN-3:0], 2'b00};
    assign pc_d   = (ctl.is_branch && alu_zero) ? pc_tgt : pc_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = src_b;
    assign dmem_we    = ctl.mem_write && !rst;
endmodule

// File: rtl/onecyc_chk.sv
module onecyc_chk
    import onecyc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_rdata,
    input logic [XLEN-1:0] dmem_addr,
    input logic [XLEN-1:0] dmem_wdata,
    input logic            dmem_we,
    input logic [XLEN-1:0] dmem_rdata
);
    logic [5:0]      opc;
    logic [XLEN-1:0] boff;

    assign opc  = imem_rdata[31:26];
    assign boff = {{(XLEN-18){imem_rdata[15]}}, imem_rdata[15:0], 2'b00};

    // R1
    pc_reset_chk: assert property (@(posedge clk) rst |=> imem_addr == '0);

    // R1
    no_write_in_reset_chk: assert property (@(posedge clk) rst |-> !dmem_we);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_BREQ) |=> imem_addr == $past(imem_addr) + XLEN'(4));

    // R8
    branch_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BREQ) |=> (imem_addr == $past(imem_addr) + XLEN'(4)) ||
                              (imem_addr == $past(imem_addr) + XLEN'(4) + $past(boff)));

    // R7
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> opc == OPC_STOR);

    // R9
    zero_reg_store_chk: assert property (@(posedge clk) disable iff (rst)
        (dmem_we && imem_rdata[20:16] == 5'd0) |-> dmem_wdata == '0);

    // R10
    unknown_op_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_REG && opc != OPC_ORI && opc != OPC_LOAD &&
         opc != OPC_STOR && opc != OPC_BREQ) |-> !dmem_we);
endmodule

bind onecyc_cpu onecyc_chk u_chk (.*);

// File: tb/tb_onecyc_cpu.sv
module tb_onecyc_cpu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [31:0] exp_pc_q [$];
    logic [63:0] exp_st_q [$];
    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    onecyc_cpu dut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] r_ins(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'h00, fn};
    endfunction

    function automatic logic [31:0] i_ins(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic exp_pc(input int idx);
        exp_pc_q.push_back(32'(idx * 4));
    endtask

    task automatic exp_st(input logic [31:0] a, input logic [31:0] d);
        exp_st_q.push_back({a, d});
    endtask

    // Driver: loads the program and pushes the expected trace.
    task automatic drive_program();
        for (int k = 0; k < 64; k++) begin
            imem[k] = 32'hFFFF_FFFF;
            dmem[k] = 32'h0;
        end
        dmem[14] = 32'hCAFE_F00D;
        imem[0]  = i_ins(6'h0D, 0, 1, 16'h8005);   // R5 zero-extension
        imem[1]  = i_ins(6'h0D, 0, 2, 16'h0003);
        imem[2]  = r_ins(1, 2, 3, 6'h21);           // R3
        imem[3]  = r_ins(2, 1, 4, 6'h23);           // R4
        imem[4]  = i_ins(6'h2B, 0, 3, 16'h0010);
        imem[5]  = i_ins(6'h2B, 0, 4, 16'h0014);
        imem[6]  = i_ins(6'h2B, 0, 1, 16'h0000);
        imem[7]  = i_ins(6'h0D, 0, 0, 16'h1234);   // R9 write to r0
        imem[8]  = i_ins(6'h2B, 0, 0, 16'h0018);
        imem[9]  = i_ins(6'h0D, 0, 6, 16'h0040);
        imem[10] = i_ins(6'h23, 6, 7, 16'hFFF8);   // R6 negative offset
        imem[11] = i_ins(6'h2B, 6, 7, 16'h0004);
        imem[12] = 32'hFC22_5555;                   // R10 unknown opcode
        imem[13] = r_ins(2, 2, 1, 6'h20);           // R10 unknown function
        imem[14] = i_ins(6'h2B, 0, 1, 16'h001C);
        imem[15] = i_ins(6'h04, 1, 2, 16'h0005);   // R8 not taken
        imem[16] = i_ins(6'h04, 2, 2, 16'h0002);   // R8 forward taken
        imem[17] = i_ins(6'h2B, 0, 2, 16'h0020);
        imem[18] = i_ins(6'h2B, 0, 2, 16'h0020);
        imem[19] = i_ins(6'h0D, 0, 9, 16'h0000);
        imem[20] = i_ins(6'h0D, 0, 10, 16'h0009);
        imem[21] = r_ins(9, 2, 9, 6'h21);           // R11 written then read
        imem[22] = i_ins(6'h04, 9, 10, 16'h0001);
        imem[23] = i_ins(6'h04, 0, 0, 16'hFFFD);   // R8 backward
        imem[24] = i_ins(6'h2B, 0, 9, 16'h0024);
        imem[25] = r_ins(9, 9, 11, 6'h21);
        imem[26] = i_ins(6'h2B, 0, 11, 16'h0028);
        imem[27] = i_ins(6'h04, 0, 0, 16'hFFFF);   // halt loop

        for (int k = 0; k <= 16; k++) exp_pc(k);
        exp_pc(19); exp_pc(20);
        for (int k = 0; k < 2; k++) begin
            exp_pc(21); exp_pc(22); exp_pc(23);
        end
        exp_pc(21); exp_pc(22);
        exp_pc(24); exp_pc(25); exp_pc(26); exp_pc(27);

        exp_st(32'h10, 32'h0000_8008);
        exp_st(32'h14, 32'hFFFF_7FFE);
        exp_st(32'h00, 32'h0000_8005);
        exp_st(32'h18, 32'h0000_0000);
        exp_st(32'h44, 32'hCAFE_F00D);
        exp_st(32'h1C, 32'h0000_8005);
        exp_st(32'h24, 32'h0000_0009);
        exp_st(32'h28, 32'h0000_0012);
    endtask

    // Monitor: pops and compares one cycle of observed activity.
    task automatic monitor_cycle();
        logic [31:0] epc;
        logic [63:0] est;
        epc = (exp_pc_q.size() != 0) ? exp_pc_q.pop_front() : 32'd108;
        check(imem_addr == epc, "R2/R8 fetch address", imem_addr, epc);
        if (dmem_we) begin
            if (exp_st_q.size() == 0) begin
                check(1'b0, "R7/R10 unexpected store", dmem_addr, 32'hx);
            end else begin
                est = exp_st_q.pop_front();
                check(dmem_addr == est[63:32], "R6/R7 store address", dmem_addr, est[63:32]);
                check(dmem_wdata == est[31:0], "R3/R4/R5/R9/R11 store data", dmem_wdata, est[31:0]);
            end
        end
    endtask

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        drive_program();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(imem_addr == 32'h0, "R1 PC after reset", imem_addr, 32'h0);
        check(dmem_we == 1'b0, "R1 no store in reset", {31'h0, dmem_we}, 32'h0);
        rst = 1'b0;
        for (int c = 0; c < 45; c++) begin
            #1;
            monitor_cycle();
            @(negedge clk);
        end
        check(exp_st_q.size() == 0, "R7 all stores seen", exp_st_q.size(), 32'h0);
        check(dmem[4] == 32'h0000_8008, "R7 memory updated at edge", dmem[4], 32'h0000_8008);
        check(dmem[8] == 32'h0, "R8 skipped stores absent", dmem[8], 32'h0);
        check(dmem[7] == 32'h0000_8005, "R10 r1 unchanged", dmem[7], 32'h0000_8005);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule